// File: doc/BRIEF.md
# H-Bridge Fault and Protection Manager

This block sits between a host-written bridge command and the gate-drive stage of one H-bridge. It turns the two command bits into four gate enables (a high-side and a low-side switch for each leg) and watches four raw protection flags: overcurrent, over-temperature, supply undervoltage and current limit. The flags pass through a synchronizer and, where the behaviour calls for it, a persistence timer. Each cause records a sticky bit in an 8-bit status word, pulls an active-low fault line, and, depending on the cause, forces the bridge off.

The causes behave differently. Overcurrent is filtered by a short deglitch window and then latches the bridge off until the host clears it. Over-temperature and undervoltage force the bridge off only while they are present, so operation resumes by itself. A long current-limit event is only reported and the bridge keeps driving. The host clears every sticky bit with a one-cycle clear strobe. Commanding coast also drops the current-limit record and holds its timer at zero. Coast is the power-up state and marks the low-power shutdown mode.

Top module: `bridge_guard`

## Requirements
- R1: Command bit 0 selects forward and bit 1 selects reverse. Command 00 (coast) turns all four gate enables off and raises `sleepMode`. Command 01 drives `legAHigh` and `legBLow`. Command 10 drives `legALow` and `legBHigh`. Command 11 (brake) drives `legALow` and `legBLow`. No leg ever has both of its switches enabled.
- R2: In `statusReg`, bit 0 is the OR of the sticky cause bits, bit 1 is overcurrent, bit 2 is undervoltage, bit 3 is over-temperature and bit 4 is current limit. Bits 7..5 always read 0. `faultN` is low exactly when bit 0 is set. After reset the status word is 0, `faultN` is 1 and the command is taken as coast.
- R3: Each raw flag passes a synchronizer of `SYNC_STAGES` flops. With the default of 2, a raw undervoltage flag raised before a clock edge forces `bridgeOff` after the second edge and not after the first.
- R4: An overcurrent flag that stays high for `OCP_DGL_CYC` consecutive cycles sets status bit 1 and turns off all gate enables. A shorter pulse has no effect on the status or on the gates.
- R5: Once set, the overcurrent bit and the bridge shutdown persist after the raw flag drops, until a clear strobe. After the clear, the commanded drive returns.
- R6: While over-temperature or undervoltage is present, its status bit is set and all gate enables are off. When the flag drops, the commanded drive resumes by itself, while the sticky bit and `faultN` stay asserted until a clear.
- R7: A current-limit flag held for `LIM_CYC` consecutive cycles sets status bit 4 and bit 0 and pulls `faultN` low. The gate enables keep following the command.
- R8: The current-limit timer restarts whenever the flag drops before the timeout, so two pulses of `LIM_CYC-1` cycles separated by a gap do not set the bit.
- R9: Commanding coast clears status bit 4 on the next edge and holds the current-limit timer at zero, so a limit flag during coast never sets the bit.
- R10: A clear strobe clears all sticky bits on the next edge, even if a cause is active. A cause that is still present sets its bit again one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bridgeCmd | input | 2 | Bridge command, bit 0 forward select, bit 1 reverse select |
| clearReq | input | 1 | One-cycle strobe that clears all sticky status bits |
| ocpRaw | input | 1 | Raw overcurrent flag from the sensing stage |
| tempRaw | input | 1 | Raw over-temperature flag |
| uvRaw | input | 1 | Raw supply undervoltage flag |
| limRaw | input | 1 | Raw current-limit flag |
| legAHigh | output | 1 | High-side switch enable, leg A |
| legALow | output | 1 | Low-side switch enable, leg A |
| legBHigh | output | 1 | High-side switch enable, leg B |
| legBLow | output | 1 | Low-side switch enable, leg B |
| sleepMode | output | 1 | High while the command is coast (low-power shutdown) |
| bridgeOff | output | 1 | High while a protection cause forces the bridge off |
| faultN | output | 1 | Active-low fault indication, 0 means pull the line low |
| statusReg | output | 8 | Status word laid out as in R2 |

## Verification
The bench sweeps overcurrent and current-limit pulse widths across each threshold. A timer that is off by one cycle would then either trip on a pulse one cycle short or miss a pulse of exactly the threshold length. It checks that the overcurrent shutdown outlives its flag but that thermal and supply shutdowns do not. Swapping latched and automatic recovery would leave the bridge dead or let it drive into a short. It sends a clear while a cause is still active and looks at the status word on the next two edges, which catches a clear that loses to a set or a bit that never comes back. It also holds the limit flag during coast and splits a limit event with a one-cycle gap, which exposes a timer that is not restarted.

// File: rtl/bg_pkg.sv
package bg_pkg;

  // Command encoding: bit 0 forward select, bit 1 reverse select.
  typedef enum logic [1:0] {
    CMD_COAST = 2'b00,
    CMD_FWD   = 2'b01,
    CMD_REV   = 2'b10,
    CMD_BRAKE = 2'b11
  } bridge_cmd_e;

  // Status word bit positions (fixed: host software decodes them).
  localparam int ST_ANY  = 0;
  localparam int ST_OCP  = 1;
  localparam int ST_UV   = 2;
  localparam int ST_TEMP = 3;
  localparam int ST_LIM  = 4;
  localparam int ST_W    = 8;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic setOcp;
    logic setTemp;
    logic setUv;
    logic setLim;
    logic clrAll;
    logic clrLim;
    logic holdTemp;
    logic holdUv;
  } bg_strobe_t;

endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= '0;
        else       pipe[g] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[g] <= '0;
        else       pipe[g] <= pipe[g-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/bg_timer.sv
module bg_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic level,
  input  logic restart,
  output logic hit
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] runCnt;

  // hit on the LIMIT-th consecutive cycle of level; saturates there.
  assign hit = level && !restart && (runCnt == TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runCnt <= '0;
    else if (restart || !level) runCnt <= '0;
    else if (runCnt != TOP)   runCnt <= runCnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= TOP) else $error("timer count out of range"); // R8

  if (LIMIT > 1) begin : g_restart_chk
    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
      (restart || !level) |=> !hit) else $error("timer hit right after restart"); // R8
  end

endmodule

// File: rtl/bg_ctrl.sv
module bg_ctrl
  import bg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OCP_DGL_CYC = 750,
  parameter int LIM_CYC     = 68_750_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] bridgeCmd,
  input  logic       clearReq,
  input  logic       ocpRaw,
  input  logic       tempRaw,
  input  logic       uvRaw,
  input  logic       limRaw,
  output bg_strobe_t strobe
);

  localparam int NFLAG = 4;

  logic [NFLAG-1:0] rawVec;
  logic [NFLAG-1:0] syncVec;
  logic syncOcp, syncTemp, syncUv, syncLim;
  logic ocpHit, limHit;
  logic isCoast;

  assign rawVec = {limRaw, uvRaw, tempRaw, ocpRaw};

  bg_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawVec),
    .dout(syncVec)
  );

  assign syncOcp  = syncVec[0];
  assign syncTemp = syncVec[1];
  assign syncUv   = syncVec[2];
  assign syncLim  = syncVec[3];

  assign isCoast = (bridge_cmd_e'(bridgeCmd) == CMD_COAST);

  bg_timer #(.LIMIT(OCP_DGL_CYC)) u_ocpTimer (
    .clk    (clk),
    .rstN   (rstN),
    .level  (syncOcp),
    .restart(1'b0),
    .hit    (ocpHit)
  );

  bg_timer #(.LIMIT(LIM_CYC)) u_limTimer (
    .clk    (clk),
    .rstN   (rstN),
    .level  (syncLim),
    .restart(isCoast),
    .hit    (limHit)
  );

  always_comb begin
    strobe          = '0;
    strobe.setOcp   = ocpHit;
    strobe.setTemp  = syncTemp;
    strobe.setUv    = syncUv;
    strobe.setLim   = limHit;
    strobe.clrAll   = clearReq;
    strobe.clrLim   = isCoast;
    strobe.holdTemp = syncTemp;
    strobe.holdUv   = syncUv;
  end

  AST_COAST_NO_LIM: assert property (@(posedge clk) disable iff (!rstN)
    isCoast |-> !strobe.setLim) else $error("limit set during coast"); // R9

endmodule

// File: rtl/bg_datapath.sv
module bg_datapath
  import bg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      bridgeCmd,
  input  bg_strobe_t      strobe,
  output logic            legAHigh,
  output logic            legALow,
  output logic            legBHigh,
  output logic            legBLow,
  output logic            sleepMode,
  output logic            bridgeOff,
  output logic            faultN,
  output logic [ST_W-1:0] statusReg
);

  logic ocpBit, tempBit, uvBit, limBit;
  logic anyBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocpBit  <= 1'b0;
      tempBit <= 1'b0;
      uvBit   <= 1'b0;
      limBit  <= 1'b0;
    end else if (strobe.clrAll) begin
      ocpBit  <= 1'b0;
      tempBit <= 1'b0;
      uvBit   <= 1'b0;
      limBit  <= 1'b0;
    end else begin
      ocpBit  <= ocpBit  | strobe.setOcp;
      tempBit <= tempBit | strobe.setTemp;
      uvBit   <= uvBit   | strobe.setUv;
      limBit  <= strobe.clrLim ? 1'b0 : (limBit | strobe.setLim);
    end
  end

  assign anyBit = ocpBit | tempBit | uvBit | limBit;

  always_comb begin
    statusReg          = '0;
    statusReg[ST_ANY]  = anyBit;
    statusReg[ST_OCP]  = ocpBit;
    statusReg[ST_UV]   = uvBit;
    statusReg[ST_TEMP] = tempBit;
    statusReg[ST_LIM]  = limBit;
  end

  assign faultN    = ~anyBit;
  assign bridgeOff = ocpBit | strobe.holdTemp | strobe.holdUv;
  assign sleepMode = (bridge_cmd_e'(bridgeCmd) == CMD_COAST);

  always_comb begin
    legAHigh = 1'b0;
    legALow  = 1'b0;
    legBHigh = 1'b0;
    legBLow  = 1'b0;
    if (!bridgeOff) begin
      unique case (bridge_cmd_e'(bridgeCmd))
        CMD_FWD: begin
          legAHigh = 1'b1;
          legBLow  = 1'b1;
        end
        CMD_REV: begin
          legALow  = 1'b1;
          legBHigh = 1'b1;
        end
        CMD_BRAKE: begin
          legALow  = 1'b1;
          legBLow  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(legAHigh && legALow) && !(legBHigh && legBLow)) else $error("shoot-through"); // R1

  AST_OCP_GATES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ocpBit |-> !(legAHigh || legALow || legBHigh || legBLow)) else $error("drive during overcurrent"); // R4

  AST_OCP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ocpBit && !strobe.clrAll) |=> ocpBit) else $error("overcurrent dropped without clear"); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (statusReg == '0)) else $error("clear did not empty status"); // R10

  AST_COAST_DROPS_LIM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrLim |=> !limBit) else $error("limit survived coast"); // R9

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
  import bg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OCP_DGL_CYC = 750,
  parameter int LIM_CYC     = 68_750_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] bridgeCmd,
  input  logic       clearReq,
  input  logic       ocpRaw,
  input  logic       tempRaw,
  input  logic       uvRaw,
  input  logic       limRaw,
  output logic       legAHigh,
  output logic       legALow,
  output logic       legBHigh,
  output logic       legBLow,
  output logic       sleepMode,
  output logic       bridgeOff,
  output logic       faultN,
  output logic [7:0] statusReg
);

  bg_strobe_t strobe;

  bg_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .OCP_DGL_CYC(OCP_DGL_CYC),
    .LIM_CYC    (LIM_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bridgeCmd(bridgeCmd),
    .clearReq (clearReq),
    .ocpRaw   (ocpRaw),
    .tempRaw  (tempRaw),
    .uvRaw    (uvRaw),
    .limRaw   (limRaw),
    .strobe   (strobe)
  );

  bg_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .bridgeCmd(bridgeCmd),
    .strobe   (strobe),
    .legAHigh (legAHigh),
    .legALow  (legALow),
    .legBHigh (legBHigh),
    .legBLow  (legBLow),
    .sleepMode(sleepMode),
    .bridgeOff(bridgeOff),
    .faultN   (faultN),
    .statusReg(statusReg)
  );

  AST_FAULT_PIN: assert property (@(posedge clk) disable iff (!rstN)
    faultN == (statusReg == 8'h00)) else $error("fault pin disagrees with status"); // R2

endmodule

// File: tb/bridge_guard_tb.sv
`timescale 1ns/1ps
module bridge_guard_tb;

  localparam int SYNC = 2;
  localparam int DGL  = 6;
  localparam int LIM  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] bridgeCmd = 2'b00;
  logic clearReq = 1'b0;
  logic ocpRaw = 1'b0, tempRaw = 1'b0, uvRaw = 1'b0, limRaw = 1'b0;
  logic legAHigh, legALow, legBHigh, legBLow;
  logic sleepMode, bridgeOff, faultN;
  logic [7:0] statusReg;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bridge_guard #(.SYNC_STAGES(SYNC), .OCP_DGL_CYC(DGL), .LIM_CYC(LIM)) u_dut (
    .clk(clk), .rstN(rstN), .bridgeCmd(bridgeCmd), .clearReq(clearReq),
    .ocpRaw(ocpRaw), .tempRaw(tempRaw), .uvRaw(uvRaw), .limRaw(limRaw),
    .legAHigh(legAHigh), .legALow(legALow), .legBHigh(legBHigh), .legBLow(legBLow),
    .sleepMode(sleepMode), .bridgeOff(bridgeOff), .faultN(faultN), .statusReg(statusReg)
  );

  function automatic logic [3:0] expGates(input logic [1:0] cmd, input logic off);
    if (off) return 4'b0000;
    case (cmd)
      2'b01:   return 4'b1001;
      2'b10:   return 4'b0110;
      2'b11:   return 4'b0101;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] gates();
    return {legAHigh, legALow, legBHigh, legBLow};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doClear();
    clearReq = 1'b1;
    tick(1);
    clearReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R2 reset state
    chk("R2 reset status", statusReg, 8'h00);
    chk("R2 reset faultN", faultN, 1);
    chk("R1 reset sleep", sleepMode, 1);

    // R1 command sweep, no faults
    for (int c = 0; c < 4; c++) begin
      bridgeCmd = 2'(c);
      tick(1);
      chk("R1 gates", gates(), expGates(2'(c), 1'b0));
      chk("R1 sleep", sleepMode, (c == 0));
    end

    // R3 synchronizer latency on undervoltage
    bridgeCmd = 2'b01;
    uvRaw = 1'b1;
    tick(1);
    chk("R3 off after one edge", bridgeOff, 0);
    tick(1);
    chk("R3 off after two edges", bridgeOff, 1);
    tick(2);
    chk("R6 uv status", statusReg, 8'h05);
    chk("R6 uv gates off", gates(), 4'b0000);
    uvRaw = 1'b0;
    tick(4);
    chk("R6 uv auto resume", gates(), 4'b1001);
    chk("R6 uv bit sticky", statusReg, 8'h05);
    chk("R2 faultN low", faultN, 0);
    doClear();
    chk("R10 clear uv", statusReg, 8'h00);

    // R6 temperature, all commands forced off
    tempRaw = 1'b1;
    tick(4);
    for (int c = 0; c < 4; c++) begin
      bridgeCmd = 2'(c);
      tick(1);
      chk("R6 temp gates off", gates(), expGates(2'(c), 1'b1));
    end
    chk("R6 temp status", statusReg, 8'h09);
    // R10 clear while present, re-set next edge
    clearReq = 1'b1;
    tick(1);
    clearReq = 1'b0;
    chk("R10 cleared while present", statusReg, 8'h00);
    tick(1);
    chk("R10 re-set next edge", statusReg, 8'h09);
    tempRaw = 1'b0;
    bridgeCmd = 2'b10;
    tick(4);
    chk("R6 temp auto resume", gates(), 4'b0110);
    doClear();
    chk("R10 faultN released", faultN, 1);

    // R4/R5 overcurrent width sweep
    bridgeCmd = 2'b01;
    for (int w = 1; w <= DGL + 1; w++) begin
      ocpRaw = 1'b1;
      tick(w);
      ocpRaw = 1'b0;
      tick(SYNC + 4);
      chk("R4 ocp bit", statusReg[1], (w >= DGL));
      chk("R4 ocp gates", gates(), expGates(2'b01, (w >= DGL)));
      if (w >= DGL) begin
        tick(10);
        chk("R5 ocp latched", statusReg, 8'h03);
        chk("R5 ocp still off", gates(), 4'b0000);
        doClear();
        chk("R5 ocp cleared", statusReg, 8'h00);
        chk("R5 drive restored", gates(), 4'b1001);
      end
    end

    // R2 two causes together
    ocpRaw = 1'b1;
    uvRaw = 1'b1;
    tick(DGL + SYNC + 2);
    ocpRaw = 1'b0;
    uvRaw = 1'b0;
    tick(SYNC + 2);
    chk("R2 ocp+uv status", statusReg, 8'h07);
    doClear();

    // R7 current-limit width sweep
    for (int w = LIM - 1; w <= LIM + 1; w++) begin
      bridgeCmd = 2'b11;
      limRaw = 1'b1;
      tick(w);
      limRaw = 1'b0;
      tick(SYNC + 3);
      chk("R7 lim status", statusReg, (w >= LIM) ? 8'h11 : 8'h00);
      chk("R7 bridge keeps driving", gates(), 4'b0101);
      chk("R7 faultN", faultN, (w < LIM));
      doClear();
    end

    // R8 timer restart on a gap
    bridgeCmd = 2'b01;
    limRaw = 1'b1;
    tick(LIM - 1);
    limRaw = 1'b0;
    tick(1);
    limRaw = 1'b1;
    tick(LIM - 1);
    limRaw = 1'b0;
    tick(SYNC + 3);
    chk("R8 split pulses no fault", statusReg, 8'h00);

    // R9 coast drops limit bit and blocks the timer
    limRaw = 1'b1;
    tick(LIM + SYNC + 2);
    chk("R9 lim set before coast", statusReg, 8'h11);
    bridgeCmd = 2'b00;
    tick(1);
    chk("R9 coast clears lim", statusReg, 8'h00);
    tick(LIM + 5);
    chk("R9 no lim during coast", statusReg, 8'h00);
    bridgeCmd = 2'b01;
    tick(LIM + 1);
    chk("R9 lim after leaving coast", statusReg, 8'h11);
    limRaw = 1'b0;
    doClear();
    chk("R10 final clear", statusReg, 8'h00);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule